// File: doc/BRIEF.md
# Big-Endian Load/Store Alignment Unit

This unit sits between a processor pipeline and a byte-addressed data memory that is one 32-bit word wide. On each request the pipeline presents an operation code, a base register value, a 16-bit signed displacement and, for stores, the source register value. The unit forms the effective address and checks that the access is naturally aligned for its size. It registers a memory request that carries the address, the write flag, per-lane byte enables and the write data already placed in the right lanes.

The lane order is big-endian: the byte at the lowest address of a word travels on the most significant lane. Aligned loads remember which lanes were addressed and how the result should be extended. When the memory returns a word, the unit picks out the addressed byte or halfword and sign- or zero-extends it to 32 bits. A misaligned access is never split. It is dropped and an alignment error flag is raised for one cycle.

Top module: `lsu_align_unit`

## Requirements
- R1: For a request with a listed operation code, mem_addr one cycle later equals req_base plus req_offset sign-extended to 32 bits, modulo 2^32. This holds whether or not the access is aligned.
- R2: An aligned store sets mem_req and mem_we. Its enables use bit 3 for byte offset 0 and bit 0 for byte offset 3. A byte store gives 4'b1000 shifted right by the byte offset. A halfword store gives 4'b1100 at offset 0 and 4'b0011 at offset 2. A word store gives 4'b1111. Loads drive mem_be to 4'b0000.
- R3: Store data is replicated across lanes. A byte store drives req_wdata[7:0] on all four lanes. A halfword store drives req_wdata[15:0] on both halves. A word store passes req_wdata unchanged. The unused upper source bits have no effect.
- R4: A word access with address bits [1:0] not 00, or a halfword access with address bit 0 set, raises align_err for one cycle with mem_req=0 and mem_be=4'b0000. Byte accesses are never misaligned.
- R5: An aligned word load (op 0x23) returns the memory word unchanged on ld_data.
- R6: A halfword load takes mem_rdata[31:16] at offset 0 and mem_rdata[15:0] at offset 2. Op 0x21 sign-extends the result and op 0x25 zero-extends it.
- R7: A byte load at offset k takes mem_rdata[31-8k:24-8k]. Op 0x20 sign-extends the result and op 0x24 zero-extends it.
- R8: A cycle with req_valid low produces no access and no error. So does a request whose code is outside the set 0x20, 0x21, 0x23, 0x24, 0x25 (loads) and 0x28, 0x29, 0x2b (byte, halfword and word stores).
- R9: ld_valid is raised exactly one cycle after mem_rvalid. ld_data is shaped by the most recent aligned load issued; later ignored or misaligned requests do not change it.
- R10: While rst_n is low, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 6 | Operation code |
| req_base | input | 32 | Base register value |
| req_offset | input | 16 | Signed displacement |
| req_wdata | input | 32 | Store source register value |
| mem_rvalid | input | 1 | Memory read word valid |
| mem_rdata | input | 32 | Memory read word, lane 0 in bits 31:24 |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 32 | Effective byte address |
| mem_be | output | 4 | Byte-lane write enables |
| mem_wdata | output | 32 | Lane-placed write data |
| align_err | output | 1 | Misaligned access dropped |
| ld_valid | output | 1 | Load result valid |
| ld_data | output | 32 | Extended load result |

## Verification
The hardest case to reach from the ports is a load result that must be shaped by a load issued several cycles earlier. Other traffic reaches the unit in between, and a wrong context register would quietly pick the wrong lane. The bench issues an aligned byte load and follows it with a misaligned halfword load and a request with an unlisted code. Only then does it return the memory word, and it checks that the lane of the first load is used. Negative displacements are also used so that the effective address wraps below the base.

// File: rtl/lsu_align_pkg.sv
package lsu_align_pkg;

  localparam int unsigned LSU_DATA_W   = 32;
  localparam int unsigned LSU_LANES    = LSU_DATA_W / 8;
  localparam int unsigned LSU_LANE_IW  = $clog2(LSU_LANES);

  typedef enum logic [5:0] {
    OP_LD_B  = 6'h20,
    OP_LD_H  = 6'h21,
    OP_LD_W  = 6'h23,
    OP_LD_BU = 6'h24,
    OP_LD_HU = 6'h25,
    OP_ST_B  = 6'h28,
    OP_ST_H  = 6'h29,
    OP_ST_W  = 6'h2b
  } mem_op_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } acc_size_e;

  typedef struct packed {
    logic      known;
    logic      is_store;
    logic      sign_ext;
    acc_size_e size;
  } acc_kind_t;

  function automatic acc_kind_t decode_op(input logic [5:0] op);
    acc_kind_t k;
    k = '{known: 1'b1, is_store: 1'b0, sign_ext: 1'b0, size: SZ_WORD};
    case (op)
      OP_LD_B:  begin k.size = SZ_BYTE; k.sign_ext = 1'b1; end
      OP_LD_H:  begin k.size = SZ_HALF; k.sign_ext = 1'b1; end
      OP_LD_W:  k.size = SZ_WORD;
      OP_LD_BU: k.size = SZ_BYTE;
      OP_LD_HU: k.size = SZ_HALF;
      OP_ST_B:  begin k.size = SZ_BYTE; k.is_store = 1'b1; end
      OP_ST_H:  begin k.size = SZ_HALF; k.is_store = 1'b1; end
      OP_ST_W:  begin k.size = SZ_WORD; k.is_store = 1'b1; end
      default:  k.known = 1'b0;
    endcase
    return k;
  endfunction

  function automatic logic is_misaligned(input acc_size_e sz,
                                         input logic [LSU_LANE_IW-1:0] lo);
    case (sz)
      SZ_WORD: return |lo;
      SZ_HALF: return lo[0];
      default: return 1'b0;
    endcase
  endfunction

  // lane index 0 (lowest address) maps to the most significant enable bit
  function automatic logic [LSU_LANES-1:0] lane_mask(input acc_size_e sz,
                                                     input logic [LSU_LANE_IW-1:0] lo);
    logic [LSU_LANES-1:0] top_one;
    top_one = {1'b1, {(LSU_LANES-1){1'b0}}};
    case (sz)
      SZ_WORD: return '1;
      SZ_HALF: return lo[1] ? LSU_LANES'(2'b11) : LSU_LANES'(4'b1100);
      default: return top_one >> lo;
    endcase
  endfunction

  function automatic logic [LSU_DATA_W-1:0] extend_val(input logic [15:0] v,
                                                       input acc_size_e sz,
                                                       input logic sgn);
    logic fill;
    if (sz == SZ_BYTE) begin
      fill = sgn & v[7];
      return {{(LSU_DATA_W-8){fill}}, v[7:0]};
    end
    fill = sgn & v[15];
    return {{(LSU_DATA_W-16){fill}}, v};
  endfunction

endpackage

// File: rtl/lsu_addr_gen.sv
module lsu_addr_gen
  import lsu_align_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned OFS_W  = 16
) (
  input  logic [ADDR_W-1:0]      base,
  input  logic [OFS_W-1:0]       ofs,
  input  acc_size_e              size,
  output logic [ADDR_W-1:0]      eff_addr,
  output logic                   misalign
);
  localparam int unsigned EXT_W = ADDR_W - OFS_W;

  logic [ADDR_W-1:0] ofs_ext;

  assign ofs_ext  = {{EXT_W{ofs[OFS_W-1]}}, ofs};
  assign eff_addr = base + ofs_ext;
  assign misalign = is_misaligned(size, eff_addr[LSU_LANE_IW-1:0]);
endmodule

// File: rtl/lsu_store_lane.sv
module lsu_store_lane
  import lsu_align_pkg::*;
(
  input  acc_size_e              size,
  input  logic [LSU_LANE_IW-1:0] lo,
  input  logic [LSU_DATA_W-1:0]  src,
  output logic [LSU_DATA_W-1:0]  lane_data,
  output logic [LSU_LANES-1:0]   lane_en
);
  assign lane_en = lane_mask(size, lo);

  for (genvar i = 0; i < LSU_LANES; i++) begin : g_lane
    localparam int unsigned LANE_HI = LSU_DATA_W - 1 - 8 * i;
    localparam int unsigned HALF_HI = (i % 2 == 0) ? 15 : 7;
    logic [7:0] lane_byte;
    always_comb begin
      case (size)
        SZ_BYTE: lane_byte = src[7:0];
        SZ_HALF: lane_byte = src[HALF_HI -: 8];
        default: lane_byte = src[LANE_HI -: 8];
      endcase
    end
    assign lane_data[LANE_HI -: 8] = lane_byte;
  end
endmodule

// File: rtl/lsu_load_extract.sv
module lsu_load_extract
  import lsu_align_pkg::*;
(
  input  logic [LSU_DATA_W-1:0]  word,
  input  logic [LSU_LANE_IW-1:0] lo,
  input  acc_size_e              size,
  input  logic                   sign_ext,
  output logic [LSU_DATA_W-1:0]  result
);
  logic [7:0] lanes [LSU_LANES];

  for (genvar i = 0; i < LSU_LANES; i++) begin : g_pick
    localparam int unsigned LANE_HI = LSU_DATA_W - 1 - 8 * i;
    assign lanes[i] = word[LANE_HI -: 8];
  end

  logic [LSU_LANE_IW-1:0] hi_idx;
  logic [LSU_LANE_IW-1:0] lo_idx;
  logic [15:0]            half_val;

  assign hi_idx   = {lo[LSU_LANE_IW-1:1], 1'b0};
  assign lo_idx   = {lo[LSU_LANE_IW-1:1], 1'b1};
  assign half_val = {lanes[hi_idx], lanes[lo_idx]};

  always_comb begin
    case (size)
      SZ_BYTE: result = extend_val({8'h00, lanes[lo]}, SZ_BYTE, sign_ext);
      SZ_HALF: result = extend_val(half_val, SZ_HALF, sign_ext);
      default: result = word;
    endcase
  end
endmodule

// File: rtl/lsu_align_unit.sv
module lsu_align_unit
  import lsu_align_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned OFS_W  = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  input  logic [5:0]            req_op,
  input  logic [ADDR_W-1:0]     req_base,
  input  logic [OFS_W-1:0]      req_offset,
  input  logic [LSU_DATA_W-1:0] req_wdata,
  input  logic                  mem_rvalid,
  input  logic [LSU_DATA_W-1:0] mem_rdata,
  output logic                  mem_req,
  output logic                  mem_we,
  output logic [ADDR_W-1:0]     mem_addr,
  output logic [LSU_LANES-1:0]  mem_be,
  output logic [LSU_DATA_W-1:0] mem_wdata,
  output logic                  align_err,
  output logic                  ld_valid,
  output logic [LSU_DATA_W-1:0] ld_data
);
  acc_kind_t              kind;
  logic [ADDR_W-1:0]      eff_addr;
  logic                   misalign;
  logic [LSU_DATA_W-1:0]  st_lanes;
  logic [LSU_LANES-1:0]   st_en;
  logic [LSU_DATA_W-1:0]  ld_shaped;

  // named events for the checker
  logic acc_accept;
  logic acc_reject;
  logic acc_issue;
  logic ld_issue;

  logic [LSU_LANE_IW-1:0] ctx_lo;
  acc_size_e              ctx_size;
  logic                   ctx_sign;

  assign kind       = decode_op(req_op);
  assign acc_accept = req_valid & kind.known;
  assign acc_reject = acc_accept & misalign;
  assign acc_issue  = acc_accept & ~misalign;
  assign ld_issue   = acc_issue & ~kind.is_store;

  lsu_addr_gen #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) i_addr (
    .base     (req_base),
    .ofs      (req_offset),
    .size     (kind.size),
    .eff_addr (eff_addr),
    .misalign (misalign)
  );

  lsu_store_lane i_st (
    .size      (kind.size),
    .lo        (eff_addr[LSU_LANE_IW-1:0]),
    .src       (req_wdata),
    .lane_data (st_lanes),
    .lane_en   (st_en)
  );

  lsu_load_extract i_ld (
    .word     (mem_rdata),
    .lo       (ctx_lo),
    .size     (ctx_size),
    .sign_ext (ctx_sign),
    .result   (ld_shaped)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_be    <= '0;
      mem_wdata <= '0;
      align_err <= 1'b0;
      ctx_lo    <= '0;
      ctx_size  <= SZ_WORD;
      ctx_sign  <= 1'b0;
    end else begin
      mem_req   <= acc_issue;
      mem_we    <= acc_issue & kind.is_store;
      align_err <= acc_reject;
      mem_be    <= (acc_issue & kind.is_store) ? st_en : '0;
      if (acc_accept) begin
        mem_addr <= eff_addr;
      end
      if (acc_issue & kind.is_store) begin
        mem_wdata <= st_lanes;
      end
      if (ld_issue) begin
        ctx_lo   <= eff_addr[LSU_LANE_IW-1:0];
        ctx_size <= kind.size;
        ctx_sign <= kind.sign_ext;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ld_valid <= 1'b0;
      ld_data  <= '0;
    end else begin
      ld_valid <= mem_rvalid;
      if (mem_rvalid) begin
        ld_data <= ld_shaped;
      end
    end
  end
endmodule

// File: rtl/lsu_align_checker.sv
module lsu_align_checker #(
  parameter int unsigned ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              mem_rvalid,
  input logic              mem_req,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [3:0]        mem_be,
  input logic              align_err,
  input logic              ld_valid,
  input logic              acc_accept
);
  // R4: a rejected access makes no request and enables no lane
  p_err_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    align_err |-> (!mem_req && mem_be == 4'b0000));

  // R4: word enables only at a word boundary
  p_word_align_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_be == 4'b1111) |-> (mem_addr[1:0] == 2'b00));

  // R2: halfword enables match the half addressed
  p_half_lane_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_be == 4'b1100 || mem_be == 4'b0011) |->
      (mem_addr[0] == 1'b0 && mem_addr[1] == (mem_be == 4'b0011)));

  // R2: single byte enable sits on the lane of the address, big-endian
  p_byte_lane_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(mem_be) == 1) |-> (mem_be == (4'b1000 >> mem_addr[1:0])));

  // R2: enables only appear on write requests
  p_be_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_be != 4'b0000) |-> (mem_req && mem_we));

  // R8: idle cycles produce neither access nor error
  p_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!mem_req && !align_err));

  // R1: an accepted request always yields a request or an error
  p_accept_r1: assert property (@(posedge clk) disable iff (!rst_n)
    acc_accept |=> (mem_req ^ align_err));

  // R9: load result valid follows the memory return by one cycle
  p_ld_follow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rvalid |=> ld_valid);
  p_ld_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_rvalid |=> !ld_valid);
endmodule

bind lsu_align_unit lsu_align_checker #(.ADDR_W(ADDR_W)) i_lsu_align_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .mem_rvalid (mem_rvalid),
  .mem_req    (mem_req),
  .mem_we     (mem_we),
  .mem_addr   (mem_addr),
  .mem_be     (mem_be),
  .align_err  (align_err),
  .ld_valid   (ld_valid),
  .acc_accept (acc_accept)
);

// File: tb/test_lsu_align_unit.sv
module test_lsu_align_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [5:0]  req_op = 6'h00;
  logic [31:0] req_base = '0;
  logic [15:0] req_offset = '0;
  logic [31:0] req_wdata = '0;
  logic        mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        mem_req, mem_we, align_err, ld_valid;
  logic [31:0] mem_addr, mem_wdata, ld_data;
  logic [3:0]  mem_be;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  lsu_align_unit i_lsu_align_unit (
    .clk, .rst_n, .req_valid, .req_op, .req_base, .req_offset, .req_wdata,
    .mem_rvalid, .mem_rdata, .mem_req, .mem_we, .mem_addr, .mem_be,
    .mem_wdata, .align_err, .ld_valid, .ld_data
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic issue(input logic [5:0] op, input logic [31:0] base,
                       input logic [15:0] ofs, input logic [31:0] wd);
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_base = base;
    req_offset = ofs; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic t_reset();
    chk("R10", "mem_req", {31'd0, mem_req}, 32'd0);
    chk("R10", "align_err", {31'd0, align_err}, 32'd0);
    chk("R10", "mem_be", {28'd0, mem_be}, 32'd0);
    chk("R10", "ld_valid", {31'd0, ld_valid}, 32'd0);
    chk("R10", "mem_addr", mem_addr, 32'd0);
    chk("R10", "ld_data", ld_data, 32'd0);
  endtask

  task automatic t_store(input string req, input logic [5:0] op,
                         input logic [31:0] base, input logic [15:0] ofs,
                         input logic [31:0] wd, input logic [31:0] exp_addr,
                         input logic [3:0] exp_be, input logic [31:0] exp_data);
    issue(op, base, ofs, wd);
    chk(req, "store req/we", {30'd0, mem_req, mem_we}, 32'd3);
    chk("R1", "store addr", mem_addr, exp_addr);
    chk(req, "store be", {28'd0, mem_be}, {28'd0, exp_be});
    chk("R3", "store data", mem_wdata, exp_data);
  endtask

  task automatic t_load(input string req, input logic [5:0] op,
                        input logic [31:0] base, input logic [15:0] ofs,
                        input logic [31:0] word, input logic [31:0] exp_addr,
                        input logic [31:0] exp_data);
    issue(op, base, ofs, 32'hffff_ffff);
    chk(req, "load req/we", {30'd0, mem_req, mem_we}, 32'd2);
    chk("R2", "load be", {28'd0, mem_be}, 32'd0);
    chk("R1", "load addr", mem_addr, exp_addr);
    mem_rvalid = 1'b1; mem_rdata = word;
    @(negedge clk);
    mem_rvalid = 1'b0; mem_rdata = 32'h5a5a_5a5a;
    chk("R9", "ld_valid", {31'd0, ld_valid}, 32'd1);
    chk(req, "ld_data", ld_data, exp_data);
    @(negedge clk);
    chk("R9", "ld_valid drop", {31'd0, ld_valid}, 32'd0);
  endtask

  task automatic t_misalign(input logic [5:0] op, input logic [31:0] base,
                            input logic [15:0] ofs, input logic [31:0] exp_addr);
    issue(op, base, ofs, 32'h1234_5678);
    chk("R4", "err", {31'd0, align_err}, 32'd1);
    chk("R4", "req", {31'd0, mem_req}, 32'd0);
    chk("R4", "be", {28'd0, mem_be}, 32'd0);
    chk("R1", "misaligned addr", mem_addr, exp_addr);
    @(negedge clk);
    chk("R4", "err one cycle", {31'd0, align_err}, 32'd0);
  endtask

  task automatic t_ignored();
    @(negedge clk);
    req_valid = 1'b0; req_op = 6'h2b; req_base = 32'h40; req_offset = 16'h0;
    @(negedge clk);
    chk("R8", "invalid req", {30'd0, mem_req, align_err}, 32'd0);
    issue(6'h22, 32'h103, 16'h0, 32'h0);
    chk("R8", "unlisted op", {27'd0, mem_req, align_err, mem_be}, 32'd0);
  endtask

  // R9: context belongs to the last aligned load despite later traffic
  task automatic t_context();
    issue(6'h24, 32'h200, 16'h0001, 32'h0);
    issue(6'h21, 32'h200, 16'h0003, 32'h0);
    chk("R4", "ctx misaligned err", {31'd0, align_err}, 32'd1);
    issue(6'h3f, 32'h200, 16'h0002, 32'h0);
    mem_rvalid = 1'b1; mem_rdata = 32'h11f2_3344;
    @(negedge clk);
    mem_rvalid = 1'b0;
    chk("R9", "kept context", ld_data, 32'h0000_00f2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    // R2 R3 stores
    t_store("R2", 6'h2b, 32'h1000, 16'h0004, 32'haabb_ccdd, 32'h1004, 4'hf, 32'haabb_ccdd);
    t_store("R2", 6'h29, 32'h2000, 16'h0002, 32'hdead_beef, 32'h2002, 4'h3, 32'hbeef_beef);
    t_store("R2", 6'h29, 32'h2000, 16'h0000, 32'hdead_beef, 32'h2000, 4'hc, 32'hbeef_beef);
    t_store("R2", 6'h28, 32'h3000, 16'hffff, 32'h1234_56ab, 32'h2fff, 4'h1, 32'habab_abab);
    t_store("R2", 6'h28, 32'h3000, 16'h0001, 32'h0000_0077, 32'h3001, 4'h4, 32'h7777_7777);
    // R5 R6 R7 loads
    t_load("R5", 6'h23, 32'h0001_0000, 16'h8000, 32'haabb_ccdd, 32'h0000_8000, 32'haabb_ccdd);
    t_load("R6", 6'h21, 32'h100, 16'h0000, 32'haabb_ccdd, 32'h100, 32'hffff_aabb);
    t_load("R6", 6'h25, 32'h100, 16'h0000, 32'haabb_ccdd, 32'h100, 32'h0000_aabb);
    t_load("R6", 6'h21, 32'h100, 16'h0002, 32'haabb_ccdd, 32'h102, 32'hffff_ccdd);
    t_load("R6", 6'h25, 32'h104, 16'hfffe, 32'haabb_ccdd, 32'h102, 32'h0000_ccdd);
    t_load("R6", 6'h21, 32'h100, 16'h0000, 32'h12f4_5678, 32'h100, 32'h0000_12f4);
    t_load("R7", 6'h20, 32'h100, 16'h0000, 32'haabb_ccdd, 32'h100, 32'hffff_ffaa);
    t_load("R7", 6'h24, 32'h100, 16'h0001, 32'haabb_ccdd, 32'h101, 32'h0000_00bb);
    t_load("R7", 6'h20, 32'h100, 16'h0002, 32'haabb_ccdd, 32'h102, 32'hffff_ffcc);
    t_load("R7", 6'h24, 32'h100, 16'h0003, 32'haabb_ccdd, 32'h103, 32'h0000_00dd);
    t_load("R7", 6'h20, 32'h100, 16'h0000, 32'h7f00_0000, 32'h100, 32'h0000_007f);
    // R4 misaligned
    t_misalign(6'h23, 32'h100, 16'h0002, 32'h102);
    t_misalign(6'h21, 32'h100, 16'h0001, 32'h101);
    t_misalign(6'h2b, 32'h100, 16'h0003, 32'h103);
    t_misalign(6'h29, 32'h104, 16'hfffd, 32'h101);
    // R8, R9
    t_ignored();
    t_context();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule